// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block tracks the coherence state of one cache line for a small group of private caches on a shared snooping bus. The protocol has three states: Modified, Shared and Invalid. Each cache presents processor read and write requests. A fixed-priority arbiter picks one requester per cycle. The granted cache applies its own requester transition and drives a bus event. Every other cache snoops that event and updates its own copy. A snooper that holds dirty data raises a flush strobe.

Requester and snooper transitions are kept as separate pieces of logic. A write hit on a Shared line uses its own upgrade event and does not issue a full read-exclusive. The bus event, the flush strobe and the index of the flushing cache are combinational in the cycle of the grant. The line states are registered and take their new values at the next rising edge. A cache that is not granted must keep its request asserted until it is granted.

Top module: `msi_coherence_ctrl`

## Requirements
- R1: During synchronous reset (`rst_n` low at a rising edge), every cache's line state becomes Invalid. State field `line_state[2i+1:2i]` of cache i is encoded as 0 = Invalid, 1 = Shared, 2 = Modified.
- R2: At most one `grant` bit is high in a cycle. It belongs to the lowest-indexed cache with `req_rd` or `req_wr` high, and no grant is given when no cache is requesting.
- R3: A granted read to a line in Invalid drives `bus_event` = 1 (read) and moves that cache to Shared at the next edge.
- R4: A granted read to a line in Shared or Modified drives `bus_event` = 0 (none) and leaves that cache's state unchanged.
- R5: A granted write moves the cache to Modified. From Invalid it drives `bus_event` = 2 (read-exclusive), from Shared it drives `bus_event` = 3 (upgrade), and from Modified it drives `bus_event` = 0.
- R6: A snooper in Modified that sees a read event raises `flush` with `flush_idx` equal to its own index, in the same cycle, and moves to Shared.
- R7: A snooper in Modified that sees a read-exclusive event raises `flush` with `flush_idx` equal to its own index and moves to Invalid.
- R8: A snooper in Shared moves to Invalid on a read-exclusive or an upgrade event, and stays Shared on a read event.
- R9: A snooper in Invalid stays Invalid for every bus event.
- R10: At every edge, at most one cache holds the line in Modified, and while one does, all the others hold it in Invalid.
- R11: When a granted cache has both `req_rd` and `req_wr` high, the write is the request that is served.
- R12: `flush` is low whenever no snooper holds the line in Modified, and `flush_idx` is 0 while `flush` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_rd | input | N_CACHE | Per-cache processor read request |
| req_wr | input | N_CACHE | Per-cache processor write request |
| grant | output | N_CACHE | One-hot bus grant for this cycle |
| line_state | output | 2*N_CACHE | Registered per-cache state, two bits per cache |
| bus_event | output | 2 | Event driven by the granted cache (0 none, 1 read, 2 read-exclusive, 3 upgrade) |
| flush | output | 1 | A snooper is writing its dirty copy back |
| flush_idx | output | IDX_W | Index of the flushing cache |

## Verification
A single walk through the protocol covers every requester transition (read miss, read hit in Shared and in Modified, write from each of the three states) against caches that hold assorted mixes of states. Each of these inputs tells a different thing apart. Reads into a Modified owner separate a flush followed by Shared from a flush followed by Invalid. Upgrades and read-exclusives against Shared holders separate invalidation from retention. Reads that reach Invalid snoopers show that those snoopers never wake up. Simultaneous requests show whether the lowest index wins, a combined read and write shows whether the write is served, and an idle cycle and a mid-run reset test the quiet and reset paths. The single-writer invariant is checked after every edge.

// File: rtl/msi_pkg.sv
// Package: shared encodings for the MSI coherence controller.
// Assumes: two-bit state and event codes are visible at the top ports.
package msi_pkg;
    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_MOD = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RD   = 2'd1,
        EV_RDX  = 2'd2,
        EV_UPG  = 2'd3
    } bus_ev_t;
endpackage

// File: rtl/msi_arbiter.sv
// Module: fixed-priority arbiter, lowest index wins.
// Assumes: requesters hold their request until granted; combinational grant.
module msi_arbiter #(
    parameter int N_CACHE = 4,
    parameter int IDX_W   = (N_CACHE > 1) ? $clog2(N_CACHE) : 1
) (
    input  logic [N_CACHE-1:0] req,
    output logic [N_CACHE-1:0] gnt,
    output logic [IDX_W-1:0]   gnt_idx,
    output logic               gnt_vld
);
    // Pick the lowest-indexed active request.
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        gnt_vld = 1'b0;
        for (int i = 0; i < N_CACHE; i++) begin
            if (req[i] && !gnt_vld) begin
                gnt[i]  = 1'b1;
                gnt_idx = IDX_W'(i);
                gnt_vld = 1'b1;
            end
        end
    end
endmodule

// File: rtl/msi_req_logic.sv
// Module: requester transition for the granted cache.
// Assumes: a write takes precedence over a read from the same cache.
module msi_req_logic
    import msi_pkg::*;
(
    input  logic     gnt_vld,
    input  logic     do_wr,
    input  line_st_t cur_st,
    output line_st_t nxt_st,
    output bus_ev_t  ev
);
    // Map the granted cache's state and operation to a new state and bus event.
    always_comb begin
        nxt_st = cur_st;
        ev     = EV_NONE;
        if (gnt_vld) begin
            if (do_wr) begin
                nxt_st = ST_MOD;
                unique case (cur_st)
                    ST_INV:  ev = EV_RDX;
                    ST_SHR:  ev = EV_UPG;
                    default: ev = EV_NONE;
                endcase
            end else if (cur_st == ST_INV) begin
                nxt_st = ST_SHR;
                ev     = EV_RD;
            end
        end
    end
endmodule

// File: rtl/msi_cache_slot.sv
// Module: per-cache state register with the snooper transition.
// Assumes: when granted, the requester's next state is taken instead.
module msi_cache_slot
    import msi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     granted,
    input  line_st_t req_nxt,
    input  bus_ev_t  ev,
    output line_st_t st,
    output logic     flush
);
    line_st_t snp_nxt;

    // Snooper reaction to the event driven by another cache.
    always_comb begin
        snp_nxt = st;
        flush   = 1'b0;
        if (!granted) begin
            unique case (st)
                ST_SHR: begin
                    if (ev == EV_RDX || ev == EV_UPG) snp_nxt = ST_INV;
                end
                ST_MOD: begin
                    if (ev == EV_RD) begin
                        snp_nxt = ST_SHR;
                        flush   = 1'b1;
                    end else if (ev == EV_RDX) begin
                        snp_nxt = ST_INV;
                        flush   = 1'b1;
                    end else if (ev == EV_UPG) begin
                        snp_nxt = ST_INV;
                    end
                end
                default: snp_nxt = ST_INV;
            endcase
        end
    end

    // Register the line state.
    always_ff @(posedge clk) begin
        if (!rst_n)       st <= ST_INV;
        else if (granted) st <= req_nxt;
        else              st <= snp_nxt;
    end
endmodule

// File: rtl/msi_coherence_ctrl.sv
// Module: top level of the MSI snooping controller for one line.
// Assumes: at most one transaction per cycle; data movement is external.
module msi_coherence_ctrl
    import msi_pkg::*;
#(
    parameter int N_CACHE = 4,
    parameter int IDX_W   = (N_CACHE > 1) ? $clog2(N_CACHE) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CACHE-1:0]     req_rd,
    input  logic [N_CACHE-1:0]     req_wr,
    output logic [N_CACHE-1:0]     grant,
    output logic [2*N_CACHE-1:0]   line_state,
    output logic [1:0]             bus_event,
    output logic                   flush,
    output logic [IDX_W-1:0]       flush_idx
);
    logic [IDX_W-1:0]   gnt_idx;
    logic               gnt_vld;
    line_st_t           st_q [N_CACHE];
    line_st_t           req_nxt;
    bus_ev_t            ev;
    logic [N_CACHE-1:0] flush_v;

    msi_arbiter #(.N_CACHE(N_CACHE), .IDX_W(IDX_W)) u_arb (
        .req     (req_rd | req_wr),
        .gnt     (grant),
        .gnt_idx (gnt_idx),
        .gnt_vld (gnt_vld)
    );

    msi_req_logic u_req (
        .gnt_vld (gnt_vld),
        .do_wr   (req_wr[gnt_idx]),
        .cur_st  (st_q[gnt_idx]),
        .nxt_st  (req_nxt),
        .ev      (ev)
    );

    for (genvar i = 0; i < N_CACHE; i++) begin : g_slot
        msi_cache_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .granted (grant[i]),
            .req_nxt (req_nxt),
            .ev      (ev),
            .st      (st_q[i]),
            .flush   (flush_v[i])
        );
        assign line_state[2*i +: 2] = st_q[i];
    end

    // Combine the per-cache flush strobes and encode the flushing index.
    always_comb begin
        flush_idx = '0;
        for (int i = N_CACHE - 1; i >= 0; i--) begin
            if (flush_v[i]) flush_idx = IDX_W'(i);
        end
    end

    assign flush     = |flush_v;
    assign bus_event = ev;
endmodule

// File: rtl/msi_coherence_checker.sv
// Module: protocol assertions, bound to msi_coherence_ctrl.
// Assumes: synchronous active-low reset; all checks are disabled during reset.
module msi_coherence_checker
    import msi_pkg::*;
#(
    parameter int N_CACHE = 4,
    parameter int IDX_W   = (N_CACHE > 1) ? $clog2(N_CACHE) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_CACHE-1:0]   req_rd,
    input logic [N_CACHE-1:0]   req_wr,
    input logic [N_CACHE-1:0]   grant,
    input logic [2*N_CACHE-1:0] line_state,
    input logic [1:0]           bus_event,
    input logic                 flush,
    input logic [IDX_W-1:0]     flush_idx
);
    logic [N_CACHE-1:0] mod_v;
    logic [N_CACHE-1:0] inv_v;

    // Decode which caches hold the line in Modified or Invalid.
    always_comb begin
        for (int i = 0; i < N_CACHE; i++) begin
            mod_v[i] = (line_state[2*i +: 2] == ST_MOD);
            inv_v[i] = (line_state[2*i +: 2] == ST_INV);
        end
    end

    assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_single_writer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mod_v) <= 1);

    assert_owner_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_v != '0) |-> ($countones(inv_v) == N_CACHE - 1));

    assert_flush_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (bus_event == EV_RD || bus_event == EV_RDX));

    assert_flush_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (mod_v[flush_idx] && !grant[flush_idx]));

    for (genvar i = 0; i < N_CACHE; i++) begin : g_chk
        localparam logic [N_CACHE-1:0] LOW = N_CACHE'((1 << i) - 1);

        assert_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> (((req_rd | req_wr) & LOW) == '0));

        assert_rd_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] && !req_wr[i] && inv_v[i]) |=> (line_state[2*i +: 2] == ST_SHR));

        assert_wr_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] && req_wr[i]) |=> mod_v[i]);

        assert_inv_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!grant[i] && inv_v[i]) |=> (line_state[2*i +: 2] == ST_INV));
    end
endmodule

bind msi_coherence_ctrl msi_coherence_checker #(.N_CACHE(N_CACHE), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_rd     (req_rd),
    .req_wr     (req_wr),
    .grant      (grant),
    .line_state (line_state),
    .bus_event  (bus_event),
    .flush      (flush),
    .flush_idx  (flush_idx)
);

// File: tb/msi_coherence_ctrl_test.sv
// Bench: a vector walk through the protocol, then directed reset checks.
module msi_coherence_ctrl_test;
    localparam int N = 4;
    localparam int VW = 25;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_rd = '0;
    logic [N-1:0] req_wr = '0;
    logic [N-1:0] grant;
    logic [2*N-1:0] line_state;
    logic [1:0]   bus_event;
    logic         flush;
    logic [1:0]   flush_idx;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    msi_coherence_ctrl #(.N_CACHE(N)) uut (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
        .grant(grant), .line_state(line_state), .bus_event(bus_event),
        .flush(flush), .flush_idx(flush_idx)
    );

    // Fields: rd[24:21] wr[20:17] gnt[16:13] ev[12:11] fl[10] fidx[9:8] st_after[7:0]
    // State codes: c3 c2 c1 c0, two bits each, 0=I 1=S 2=M.
    localparam logic [VW-1:0] VEC [15] = '{
        {4'b0001, 4'b0000, 4'b0001, 2'd1, 1'b0, 2'd0, 8'h01}, // R3 read miss c0
        {4'b0110, 4'b0000, 4'b0010, 2'd1, 1'b0, 2'd0, 8'h05}, // R2 c1 beats c2, R9
        {4'b0100, 4'b0000, 4'b0100, 2'd1, 1'b0, 2'd0, 8'h15}, // R8 S stays on read
        {4'b0000, 4'b0010, 4'b0010, 2'd3, 1'b0, 2'd0, 8'h08}, // R5 upgrade, R8
        {4'b1000, 4'b0000, 4'b1000, 2'd1, 1'b1, 2'd1, 8'h44}, // R6 M->S flush
        {4'b1000, 4'b0010, 4'b0010, 2'd3, 1'b0, 2'd0, 8'h08}, // R2 R8 upgrade kills S
        {4'b0000, 4'b0001, 4'b0001, 2'd2, 1'b1, 2'd1, 8'h02}, // R7 M->I flush, R5
        {4'b0001, 4'b0000, 4'b0001, 2'd0, 1'b0, 2'd0, 8'h02}, // R4 read hit M
        {4'b0000, 4'b0001, 4'b0001, 2'd0, 1'b0, 2'd0, 8'h02}, // R5 write hit M
        {4'b0000, 4'b0000, 4'b0000, 2'd0, 1'b0, 2'd0, 8'h02}, // R2 idle
        {4'b0100, 4'b0100, 4'b0100, 2'd2, 1'b1, 2'd0, 8'h20}, // R11 write wins
        {4'b0010, 4'b0000, 4'b0010, 2'd1, 1'b1, 2'd2, 8'h14}, // R6 c2 flushes
        {4'b0010, 4'b0000, 4'b0010, 2'd0, 1'b0, 2'd0, 8'h14}, // R4 read hit S
        {4'b0001, 4'b0000, 4'b0001, 2'd1, 1'b0, 2'd0, 8'h15}, // R12 no owner
        {4'b0000, 4'b1000, 4'b1000, 2'd2, 1'b0, 2'd0, 8'h80}  // R8 RDX kills S
    };

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // Check the single-writer rule after every edge (R10).
    task automatic check_owner();
        int m = 0;
        int iv = 0;
        for (int i = 0; i < N; i++) begin
            if (line_state[2*i +: 2] == 2'd2) m++;
            if (line_state[2*i +: 2] == 2'd0) iv++;
        end
        check("R10", ((m <= 1) && (m == 0 || iv == N - 1)) ? 32'd1 : 32'd0, 32'd1);
    endtask

    // Watchdog: a hung run counts as one failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected below 5000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", {24'd0, line_state}, 32'd0);
        check("R2", {28'd0, grant}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < 15; v++) begin
            logic [VW-1:0] e;
            e = VEC[v];
            @(negedge clk);
            req_rd = e[24:21];
            req_wr = e[20:17];
            #1;
            check("R2", {28'd0, grant}, {28'd0, e[16:13]});
            check("R5", {30'd0, bus_event}, {30'd0, e[12:11]});
            check("R6", {31'd0, flush}, {31'd0, e[10]});
            check("R12", {30'd0, flush_idx}, {30'd0, e[9:8]});
            @(posedge clk);
            #1;
            check("R8", {24'd0, line_state}, {24'd0, e[7:0]});
            check_owner();
        end

        // Mid-run reset with a request pending.
        @(negedge clk);
        req_rd = 4'b0001;
        req_wr = '0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", {24'd0, line_state}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        req_rd = '0;
        #1;
        check("R12", {31'd0, flush}, 32'd0);
        check("R5", {30'd0, bus_event}, 32'd0);

        // After reset a write from c3 must issue read-exclusive from Invalid.
        @(negedge clk);
        req_wr = 4'b1000;
        #1;
        check("R5", {30'd0, bus_event}, 32'd2);
        @(posedge clk);
        #1;
        check("R5", {24'd0, line_state}, 32'h80);
        check_owner();
        @(negedge clk);
        req_wr = '0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule